// File: doc/BRIEF.md
# Stack and Control-Transfer Execution Unit

This unit executes the stack-related and control-transfer instructions of a small byte-wide processor. It handles procedure call and return, software interrupt and interrupt return, a hardware interrupt entry, pushing and popping one general register, and saving and restoring the status register. The fetch sequencer hands over an instruction with a one-cycle `start` pulse. Along with the pulse it supplies the opcode, the operand byte, the current instruction pointer, the stack pointer, the register file and the status register.

The unit then steps through a short state machine. It drives a single-port byte-wide RAM, which has a configurable read latency. When it finishes, it raises `done` for one cycle. In that same cycle it presents every write-back: the new IP, the new SP, a general register, or the status register.

The stack grows toward lower addresses. A push stores at the current SP and then decrements SP. A pop increments SP and then reads from the new SP. A software interrupt takes its target indirectly from a RAM vector slot named by the operand. Both return forms restore only IP. Flags are never altered, except by the status-register pop.

Top module: `stack_xfer_unit`

## Requirements
- R1: After reset, `done`, `mem_we`, `mem_re`, `ip_we`, `sp_we`, `reg_we` and `sr_we` are all low.
- R2: Opcode 0xCA with operand a: the unit writes IP+2 to RAM[SP], then finishes with SP-1 and IP=a.
- R3: Opcode 0xCC with operand n: the unit writes IP+2 to RAM[SP], then reads RAM[n], then finishes with SP-1 and IP equal to the byte read.
- R4: When `irq_take` is high with `start`, the opcode is ignored. The unit runs the 0xCC sequence with the operand as the vector slot, but the saved address is IP+1.
- R5: Opcodes 0xCB and 0xCD each read RAM[SP+1] and finish with IP equal to that byte and SP+1. Neither raises `reg_we` or `sr_we`.
- R6: Opcode 0xE0 writes a general register to RAM[SP] and finishes with SP-1 and `ip_we` low. The register is chosen by the low two operand bits: AL=0, BL=1, CL=2, DL=3. Register k occupies `regs_in[8k+7:8k]`.
- R7: Opcode 0xE1 reads RAM[SP+1] and finishes with `reg_we` high, `reg_sel` equal to the low two operand bits, `reg_wdata` equal to the byte read, and SP+1.
- R8: Opcode 0xEA writes `sr_in` to RAM[SP] and finishes with SP-1. Opcode 0xEB reads RAM[SP+1] into `sr_wdata` with `sr_we` high and SP+1. No other instruction raises `sr_we`.
- R9: SP wraps modulo 2^DW: a push at SP=0x00 stores at 0x00 and leaves 0xFF, and a pop at 0xFF reads 0x00.
- R10: Any other opcode finishes with `done` and makes no RAM access and no write-back.
- R11: Every accepted `start` yields exactly one single-cycle `done`. A read and a write are never requested in the same cycle.
- R12: Read data is taken RD_LAT cycles after `mem_re`, so `done` follows the last `mem_re` by RD_LAT+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin one instruction (accepted when idle) |
| irq_take | input | 1 | Treat this start as a hardware interrupt entry |
| opcode | input | 8 | Decoded opcode byte |
| operand | input | DW | Operand byte (address, vector slot or register code) |
| ip_in | input | DW | Address of the current instruction |
| sp_in | input | DW | Current stack pointer |
| regs_in | input | NREG*DW | General registers, register k in slice k |
| sr_in | input | DW | Current status register |
| mem_addr | output | DW | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | DW | RAM write data |
| mem_re | output | 1 | RAM read request |
| mem_rdata | input | DW | RAM read data, valid RD_LAT cycles after request |
| done | output | 1 | Instruction complete, write-backs valid |
| ip_we | output | 1 | Load IP with ip_next |
| ip_next | output | DW | New IP |
| sp_we | output | 1 | Load SP with sp_next |
| sp_next | output | DW | New SP |
| reg_we | output | 1 | Write general register |
| reg_sel | output | $clog2(NREG) | Register to write |
| reg_wdata | output | DW | Register write data |
| sr_we | output | 1 | Write status register |
| sr_wdata | output | DW | Status register write data |

## Verification
The bench builds the unit with DW=8, NREG=4 and RD_LAT=2. The non-default two-cycle latency selects the chained variant of the read-valid pipeline and makes the wait state hold for more than one cycle, which exposes any early capture of read data. With an 8-bit stack pointer, a single push at 0x00 and a pop at 0xFF are enough to reach the wrap boundary. The 4-entry register file with a 5 as operand shows that only the low code bits select a register.

// File: rtl/sxu_pkg.sv
package sxu_pkg;

   typedef enum logic [3:0] {
      K_NONE, K_CALL, K_RET, K_SWI, K_IRET, K_PUSH, K_POP, K_PUSHF, K_POPF
   } kind_e;

   typedef enum logic [2:0] {
      S_IDLE, S_WR, S_RQ, S_WT, S_FIN
   } st_e;

   localparam logic [7:0] OPC_CALL  = 8'hCA;
   localparam logic [7:0] OPC_RET   = 8'hCB;
   localparam logic [7:0] OPC_SWI   = 8'hCC;
   localparam logic [7:0] OPC_IRET  = 8'hCD;
   localparam logic [7:0] OPC_PUSH  = 8'hE0;
   localparam logic [7:0] OPC_POP   = 8'hE1;
   localparam logic [7:0] OPC_PUSHF = 8'hEA;
   localparam logic [7:0] OPC_POPF  = 8'hEB;

   function automatic logic is_push(kind_e k);
      return (k == K_CALL) || (k == K_SWI) || (k == K_PUSH) || (k == K_PUSHF);
   endfunction

   function automatic logic is_pop(kind_e k);
      return (k == K_RET) || (k == K_IRET) || (k == K_POP) || (k == K_POPF);
   endfunction

   function automatic logic loads_ip(kind_e k);
      return (k == K_CALL) || (k == K_SWI) || (k == K_RET) || (k == K_IRET);
   endfunction

endpackage

// File: rtl/sxu_decode.sv
module sxu_decode
   import sxu_pkg::*;
#(
   parameter int OPW = 8
) (
   input  logic [OPW-1:0] opcode,
   input  logic           irq_take,
   output kind_e          kind
);

   always_comb begin
      if (irq_take) begin
         kind = K_SWI;
      end else begin
         case (opcode[7:0])
            OPC_CALL:  kind = K_CALL;
            OPC_RET:   kind = K_RET;
            OPC_SWI:   kind = K_SWI;
            OPC_IRET:  kind = K_IRET;
            OPC_PUSH:  kind = K_PUSH;
            OPC_POP:   kind = K_POP;
            OPC_PUSHF: kind = K_PUSHF;
            OPC_POPF:  kind = K_POPF;
            default:   kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sxu_rdvalid.sv
module sxu_rdvalid #(
   parameter int LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic valid
);

   generate
      if (LAT == 1) begin : g_single
         logic v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q <= 1'b0;
            else        v_q <= req;
         end
         assign valid = v_q;
      end else begin : g_chain
         logic [LAT-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[LAT-2:0], req};
         end
         assign valid = sh_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/sxu_seq.sv
module sxu_seq
   import sxu_pkg::*;
#(
   parameter int DW   = 8,
   parameter int NREG = 4,
   localparam int RSW = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               irq_take,
   input  kind_e              kind,
   input  logic [DW-1:0]      operand,
   input  logic [DW-1:0]      ip_in,
   input  logic [DW-1:0]      sp_in,
   input  logic [NREG*DW-1:0] regs_in,
   input  logic [DW-1:0]      sr_in,
   input  logic               rvalid,
   input  logic [DW-1:0]      mem_rdata,
   output logic [DW-1:0]      mem_addr,
   output logic               mem_we,
   output logic [DW-1:0]      mem_wdata,
   output logic               mem_re,
   output logic               done,
   output logic               ip_we,
   output logic [DW-1:0]      ip_next,
   output logic               sp_we,
   output logic [DW-1:0]      sp_next,
   output logic               reg_we,
   output logic [RSW-1:0]     reg_sel,
   output logic [DW-1:0]      reg_wdata,
   output logic               sr_we,
   output logic [DW-1:0]      sr_wdata
);

   st_e           st;
   kind_e         kind_q;
   logic [DW-1:0] opnd_q, sp_q, wval_q, rd_addr_q, rdata_q;
   logic [DW-1:0] push_val;
   logic [RSW-1:0] rsel_in;

   assign rsel_in = operand[RSW-1:0];

   always_comb begin
      case (kind)
         K_CALL:  push_val = ip_in + DW'(2);
         K_SWI:   push_val = irq_take ? ip_in + DW'(1) : ip_in + DW'(2);
         K_PUSH:  push_val = regs_in[int'(rsel_in)*DW +: DW];
         K_PUSHF: push_val = sr_in;
         default: push_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         kind_q    <= K_NONE;
         opnd_q    <= '0;
         sp_q      <= '0;
         wval_q    <= '0;
         rd_addr_q <= '0;
         rdata_q   <= '0;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               kind_q    <= kind;
               opnd_q    <= operand;
               sp_q      <= sp_in;
               wval_q    <= push_val;
               rd_addr_q <= (kind == K_SWI) ? operand : sp_in + DW'(1);
               if (is_push(kind))     st <= S_WR;
               else if (is_pop(kind)) st <= S_RQ;
               else                   st <= S_FIN;
            end
            S_WR:  st <= (kind_q == K_SWI) ? S_RQ : S_FIN;
            S_RQ:  st <= S_WT;
            S_WT:  if (rvalid) begin
               rdata_q <= mem_rdata;
               st      <= S_FIN;
            end
            S_FIN:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign mem_we    = (st == S_WR);
   assign mem_re    = (st == S_RQ);
   assign mem_addr  = (st == S_WR) ? sp_q : rd_addr_q;
   assign mem_wdata = wval_q;

   assign done      = (st == S_FIN);
   assign sp_we     = done && (is_push(kind_q) || is_pop(kind_q));
   assign sp_next   = is_push(kind_q) ? sp_q - DW'(1) : sp_q + DW'(1);
   assign ip_we     = done && loads_ip(kind_q);
   assign ip_next   = (kind_q == K_CALL) ? opnd_q : rdata_q;
   assign reg_we    = done && (kind_q == K_POP);
   assign reg_sel   = opnd_q[RSW-1:0];
   assign reg_wdata = rdata_q;
   assign sr_we     = done && (kind_q == K_POPF);
   assign sr_wdata  = rdata_q;

endmodule

// File: rtl/stack_xfer_unit.sv
module stack_xfer_unit
   import sxu_pkg::*;
#(
   parameter int DW     = 8,
   parameter int NREG   = 4,
   parameter int OPW    = 8,
   parameter int RD_LAT = 1,
   localparam int RSW   = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               irq_take,
   input  logic [OPW-1:0]     opcode,
   input  logic [DW-1:0]      operand,
   input  logic [DW-1:0]      ip_in,
   input  logic [DW-1:0]      sp_in,
   input  logic [NREG*DW-1:0] regs_in,
   input  logic [DW-1:0]      sr_in,
   output logic [DW-1:0]      mem_addr,
   output logic               mem_we,
   output logic [DW-1:0]      mem_wdata,
   output logic               mem_re,
   input  logic [DW-1:0]      mem_rdata,
   output logic               done,
   output logic               ip_we,
   output logic [DW-1:0]      ip_next,
   output logic               sp_we,
   output logic [DW-1:0]      sp_next,
   output logic               reg_we,
   output logic [RSW-1:0]     reg_sel,
   output logic [DW-1:0]      reg_wdata,
   output logic               sr_we,
   output logic [DW-1:0]      sr_wdata
);

   generate
      if (DW < 8)                  begin : g_bad_dw  $error("DW must be at least 8");     end
      if (OPW != 8)                begin : g_bad_opw $error("OPW must be 8");             end
      if (NREG < 2 || NREG > 16)   begin : g_bad_nr  $error("NREG must be 2..16");        end
      if ((1 << RSW) != NREG)      begin : g_bad_np2 $error("NREG must be a power of 2"); end
      if (RD_LAT < 1 || RD_LAT > 8) begin : g_bad_lat $error("RD_LAT must be 1..8");      end
   endgenerate

   kind_e kind;
   logic  rvalid;

   sxu_decode #(.OPW(OPW)) i_decode (
      .opcode  (opcode),
      .irq_take(irq_take),
      .kind    (kind)
   );

   sxu_rdvalid #(.LAT(RD_LAT)) i_rdvalid (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (mem_re),
      .valid(rvalid)
   );

   sxu_seq #(.DW(DW), .NREG(NREG)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .irq_take (irq_take),
      .kind     (kind),
      .operand  (operand),
      .ip_in    (ip_in),
      .sp_in    (sp_in),
      .regs_in  (regs_in),
      .sr_in    (sr_in),
      .rvalid   (rvalid),
      .mem_rdata(mem_rdata),
      .mem_addr (mem_addr),
      .mem_we   (mem_we),
      .mem_wdata(mem_wdata),
      .mem_re   (mem_re),
      .done     (done),
      .ip_we    (ip_we),
      .ip_next  (ip_next),
      .sp_we    (sp_we),
      .sp_next  (sp_next),
      .reg_we   (reg_we),
      .reg_sel  (reg_sel),
      .reg_wdata(reg_wdata),
      .sr_we    (sr_we),
      .sr_wdata (sr_wdata)
   );

endmodule

// File: rtl/sxu_chk.sv
module sxu_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [DW-1:0] sp_in,
   input logic          mem_we,
   input logic          mem_re,
   input logic [DW-1:0] mem_addr,
   input logic          done,
   input logic          sp_we,
   input logic [DW-1:0] sp_next,
   input logic          ip_we,
   input logic          reg_we,
   input logic          sr_we
);

   logic          busy_c, wrote_c;
   logic [DW-1:0] sp_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_c  <= 1'b0;
         wrote_c <= 1'b0;
         sp_c    <= '0;
      end else begin
         if (start && !busy_c) begin
            busy_c  <= 1'b1;
            wrote_c <= 1'b0;
            sp_c    <= sp_in;
         end else begin
            if (done)   busy_c  <= 1'b0;
            if (mem_we) wrote_c <= 1'b1;
         end
      end
   end

   // R6 (also the save step of R2, R3 and R8): every write lands at the SP of the instruction
   assert_push_at_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_addr == sp_c);

   // R9: after a write the stack pointer moves down by one, modulo 2^DW
   assert_push_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sp_we && wrote_c) |-> sp_next == sp_c - DW'(1));

   // R5: after a pure read the stack pointer moves up by one
   assert_pop_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sp_we && !wrote_c) |-> sp_next == sp_c + DW'(1));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_no_rw_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_done_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy_c);

   assert_flags_only_popf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sr_we |-> (done && !ip_we && !reg_we));

endmodule

bind stack_xfer_unit sxu_chk #(.DW(DW)) i_sxu_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .sp_in   (sp_in),
   .mem_we  (mem_we),
   .mem_re  (mem_re),
   .mem_addr(mem_addr),
   .done    (done),
   .sp_we   (sp_we),
   .sp_next (sp_next),
   .ip_we   (ip_we),
   .reg_we  (reg_we),
   .sr_we   (sr_we)
);

// File: tb/test_stack_xfer_unit.sv
module test_stack_xfer_unit;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 2;

   typedef struct packed {
      logic       ipw;  logic [7:0] ip;
      logic       spw;  logic [7:0] sp;
      logic       rw;   logic [1:0] rs;  logic [7:0] rd;
      logic       srw;  logic [7:0] sr;
   } exp_t;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        start = 1'b0, irq_take = 1'b0;
   logic [7:0]  opcode = '0, operand = '0, ip_in = '0, sp_in = '0, sr_in = '0;
   logic [31:0] regs_in = 32'h44332211;
   logic [7:0]  mem_addr, mem_wdata, mem_rdata, ip_next, sp_next, reg_wdata, sr_wdata;
   logic        mem_we, mem_re, done, ip_we, sp_we, reg_we, sr_we;
   logic [1:0]  reg_sel;

   logic [7:0]  ram [256];
   logic [7:0]  rp1;

   int checks = 0, fails = 0, cyc = 0, n_done = 0, acc = 0, re_cyc = -1;
   exp_t  exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   stack_xfer_unit #(.DW(8), .NREG(4), .RD_LAT(LAT)) i_stack_xfer_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .irq_take(irq_take),
      .opcode(opcode), .operand(operand), .ip_in(ip_in), .sp_in(sp_in),
      .regs_in(regs_in), .sr_in(sr_in),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_re(mem_re), .mem_rdata(mem_rdata), .done(done),
      .ip_we(ip_we), .ip_next(ip_next), .sp_we(sp_we), .sp_next(sp_next),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .sr_we(sr_we), .sr_wdata(sr_wdata)
   );

   // RAM model with a two-cycle read latency
   always @(posedge clk) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      if (mem_re) rp1 <= ram[mem_addr];
      mem_rdata <= rp1;
   end

   function automatic exp_t mk(logic ipw, logic [7:0] ip, logic spw, logic [7:0] sp,
                               logic rw, logic [1:0] rs, logic [7:0] rd,
                               logic srw, logic [7:0] sr);
      exp_t e;
      e.ipw = ipw; e.ip = ip; e.spw = spw; e.sp = sp;
      e.rw = rw; e.rs = rs; e.rd = rd; e.srw = srw; e.sr = sr;
      return e;
   endfunction

   // Monitor: pops the scoreboard on every done pulse
   always @(negedge clk) begin
      cyc++;
      if (mem_we || mem_re) acc++;
      if (mem_re) re_cyc = cyc;
      if (done) begin
         exp_t  e, a;
         string t;
         n_done++;
         a = mk(ip_we, ip_next, sp_we, sp_next, reg_we, reg_sel, reg_wdata, sr_we, sr_wdata);
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R11 unexpected done: actual=%h expected=none", a);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (a.ipw != e.ipw || a.spw != e.spw || a.rw != e.rw || a.srw != e.srw ||
                (e.ipw && a.ip != e.ip) || (e.spw && a.sp != e.sp) ||
                (e.rw && (a.rs != e.rs || a.rd != e.rd)) || (e.srw && a.sr != e.sr)) begin
               fails++;
               $display("FAIL %s writeback: actual=%h expected=%h", t, a, e);
            end
         end
         if (re_cyc >= 0) begin
            checks++;
            if (cyc - re_cyc != LAT + 1) begin
               fails++;
               $display("FAIL R12 read-to-done: actual=%0d expected=%0d", cyc - re_cyc, LAT + 1);
            end
         end
      end
   end

   task automatic issue(input logic [7:0] op, input logic [7:0] opnd, input logic [7:0] ip,
                        input logic [7:0] sp, input logic irq, input exp_t e,
                        input int exp_acc, input string tag);
      int d0;
      @(negedge clk);
      opcode = op; operand = opnd; ip_in = ip; sp_in = sp; irq_take = irq;
      start = 1'b1; acc = 0; re_cyc = -1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      d0 = n_done;
      @(negedge clk);
      start = 1'b0; irq_take = 1'b0;
      wait (n_done != d0);
      @(negedge clk);
      checks++;
      if (acc != exp_acc) begin
         fails++;
         $display("FAIL %s RAM access count: actual=%0d expected=%0d", tag, acc, exp_acc);
      end
      checks++;
      if (exp_q.size() != 0 || n_done != d0 + 1) begin
         fails++;
         $display("FAIL R11 done count: actual=%0d expected=%0d", n_done - d0, 1);
      end
   endtask

   task automatic chk_mem(input logic [7:0] a, input logic [7:0] v, input string tag);
      checks++;
      if (ram[a] !== v) begin
         fails++;
         $display("FAIL %s RAM[%h]: actual=%h expected=%h", tag, a, ram[a], v);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) ram[i] = 8'h00;
      ram[8'h02] = 8'h50;
      ram[8'h04] = 8'h60;
      repeat (3) @(negedge clk);
      checks++;
      if (done || mem_we || mem_re || ip_we || sp_we || reg_we || sr_we) begin
         fails++;
         $display("FAIL R1 reset outputs: actual=%b expected=0000000",
                  {done, mem_we, mem_re, ip_we, sp_we, reg_we, sr_we});
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R6: push CL, then code 5 whose low bits select BL
      issue(8'hE0, 8'h02, 8'h00, 8'h80, 1'b0, mk(0,0,1,8'h7F,0,0,0,0,0), 1, "R6");
      chk_mem(8'h80, 8'h33, "R6");
      issue(8'hE0, 8'h05, 8'h00, 8'h7F, 1'b0, mk(0,0,1,8'h7E,0,0,0,0,0), 1, "R6");
      chk_mem(8'h7F, 8'h22, "R6");
      // R7: pop into DL
      issue(8'hE1, 8'h03, 8'h00, 8'h7E, 1'b0, mk(0,0,1,8'h7F,1,2'd3,8'h22,0,0), 1, "R7");
      // R8: status register save and restore
      sr_in = 8'hA5;
      issue(8'hEA, 8'h00, 8'h00, 8'h7F, 1'b0, mk(0,0,1,8'h7E,0,0,0,0,0), 1, "R8");
      chk_mem(8'h7F, 8'hA5, "R8");
      sr_in = 8'h00;
      issue(8'hEB, 8'h00, 8'h00, 8'h7E, 1'b0, mk(0,0,1,8'h7F,0,0,0,1,8'hA5), 1, "R8");
      // R2 then R5: call and return
      issue(8'hCA, 8'h30, 8'h10, 8'h90, 1'b0, mk(1,8'h30,1,8'h8F,0,0,0,0,0), 1, "R2");
      chk_mem(8'h90, 8'h12, "R2");
      issue(8'hCB, 8'h00, 8'h30, 8'h8F, 1'b0, mk(1,8'h12,1,8'h90,0,0,0,0,0), 1, "R5");
      // R3 then R5: software interrupt through slot 02 and return
      issue(8'hCC, 8'h02, 8'h20, 8'hA0, 1'b0, mk(1,8'h50,1,8'h9F,0,0,0,0,0), 2, "R3");
      chk_mem(8'hA0, 8'h22, "R3");
      issue(8'hCD, 8'h00, 8'h50, 8'h9F, 1'b0, mk(1,8'h22,1,8'hA0,0,0,0,0,0), 1, "R5");
      // R4: hardware entry with a call opcode present, slot 04, return address IP+1
      issue(8'hCA, 8'h04, 8'h33, 8'hC0, 1'b1, mk(1,8'h60,1,8'hBF,0,0,0,0,0), 2, "R4");
      chk_mem(8'hC0, 8'h34, "R4");
      // R9: wrap at both ends
      issue(8'hE0, 8'h00, 8'h00, 8'h00, 1'b0, mk(0,0,1,8'hFF,0,0,0,0,0), 1, "R9");
      chk_mem(8'h00, 8'h11, "R9");
      issue(8'hE1, 8'h01, 8'h00, 8'hFF, 1'b0, mk(0,0,1,8'h00,1,2'd1,8'h11,0,0), 1, "R9");
      // R10: unrelated opcodes do nothing
      issue(8'hA0, 8'h01, 8'h40, 8'h50, 1'b0, mk(0,0,0,0,0,0,0,0,0), 0, "R10");
      issue(8'hFF, 8'h00, 8'h41, 8'h50, 1'b0, mk(0,0,0,0,0,0,0,0,0), 0, "R10");

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule